// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs the byte-level sequence of an I2C master transfer. Software writes a 16-bit control word and a programmed byte count. The block then drives a byte-level bus engine through a command handshake: start with address and direction, send a byte and sample the acknowledge, receive a byte, and stop. Bit timing on SCL/SDA belongs to that engine and is not part of this block.

Data passes through a small holding buffer, four bytes deep by default. In transmit, software pushes bytes into it and the sequencer drains them to the bus. In receive, the sequencer fills it from the bus and software pops the bytes. In count mode the working count is loaded from the programmed count when the address is acknowledged. Each byte moved decrements it. When it reaches zero, the sequencer either flags access-ready and drops master, or issues a stop if software asked for one. In repeat mode the count is ignored and the transfer ends only on a software stop request.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A control write stores `ctrl_wdata_i & 16'hCF87`, and `ctrl_o` shows the stored word. The bit fields are: start 0, stop 1, repeat 2, 10-bit address 8, transmit 9, master 10, enable 15. Reset clears it to 0.
- R2: A control write starts a transfer when it has enable, master and start set, has the 10-bit bit clear, the sequencer is idle, and `bus_busy_i` is low. The block then issues command 0 (start) with `cmd_addr_o = sa_i` and `cmd_rd_o` equal to the inverse of transmit. The start bit self-clears and the holding buffer is emptied. A command is held with a stable code until `done_i`.
- R3: An unacknowledged start sets status NACK (`stat_o[0]`) and clears the stop bit. No data is moved and the working count is left unchanged.
- R4: In count transmit, command 1 (send) sends buffered bytes in push order while the count is nonzero, decrementing the count once per byte. Transmit-ready (`stat_o[3]`) is 1 after an acknowledged byte that leaves count remaining, and 0 once the count is exhausted. Software pushes are accepted only while the latched direction is transmit.
- R5: In count receive, command 2 (receive) fills the buffer up to its depth while the count is nonzero. The fill resumes as software pops bytes. Receive-ready (`stat_o[2]`) is 1 whenever a received byte is buffered. `rx_byte_o` shows the oldest byte.
- R6: When the count is zero with stop set, the block issues command 3 (stop), clears the stop bit and reloads the working count. With stop clear, it sets access-ready (`stat_o[1]`) and clears master. A count of zero completes right after the address phase.
- R7: In repeat mode the count is neither checked nor decremented. Transmit drains the buffer, receive fills it, and a stop request ends the transfer with command 3.
- R8: A data byte that is not acknowledged sets NACK, clears the stop bit and transmit-ready, and ends the data phase. The working count still counts that byte.
- R9: A control write with enable clear resets the controller. The control word, status, both counts and the buffer all go to zero.
- R10: A start request is ignored, with the start bit left set, when `bus_busy_i` is high, when master is clear, or when the 10-bit bit is set.
- R11: `cnt_cur_o` shows the working count at all times. Writing ones on `stat_clr_i[1:0]` clears NACK and access-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 16 | Control word write data |
| ctrl_o | output | 16 | Stored control word |
| cnt_we_i | input | 1 | Programmed count write strobe |
| cnt_wdata_i | input | CNT_W | Programmed count value |
| cnt_cur_o | output | CNT_W | Working byte count |
| sa_i | input | 7 | Slave address for the next start |
| stat_clr_i | input | 4 | Write-one-to-clear for status bits 1:0 |
| stat_o | output | 4 | {xrdy, rrdy, ardy, nack} |
| tx_push_i | input | 1 | Push a transmit byte |
| tx_byte_i | input | 8 | Transmit byte |
| rx_pop_i | input | 1 | Pop the oldest received byte |
| rx_byte_o | output | 8 | Oldest buffered byte |
| cmd_valid_o | output | 1 | Bus engine command pending |
| cmd_o | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| cmd_addr_o | output | 7 | Address for the start command |
| cmd_rd_o | output | 1 | Direction for the start command, 1 is read |
| cmd_data_o | output | 8 | Byte for the send command |
| done_i | input | 1 | Engine finished the pending command |
| ack_i | input | 1 | Acknowledge seen with done_i |
| rdata_i | input | 8 | Received byte with done_i |
| bus_busy_i | input | 1 | Engine holds the bus |

## Verification
The checker watches several properties on every cycle. The control word never holds a bit outside the kept mask. A pending command keeps its code until the engine answers. A start is never issued while the bus was busy. A send in count mode never happens at a zero count. A NACK on start or data always leaves the NACK flag set and the stop bit clear, and access-ready only rises together with master dropping. The directed scenarios show what needs a transfer history: the order of bytes on the bus, the buffer-full stall and its resumption on pops, and the count reload after a stop. They also cover repeat mode running past the count, the full reset on disable, and start requests that are refused.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int CTRL_W = 16;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 16'hCF87;

  localparam int B_STT = 0;
  localparam int B_STP = 1;
  localparam int B_RPT = 2;
  localparam int B_XA  = 8;
  localparam int B_TRX = 9;
  localparam int B_MST = 10;
  localparam int B_EN  = 15;

  localparam int S_NACK = 0;
  localparam int S_ARDY = 1;
  localparam int S_RRDY = 2;
  localparam int S_XRDY = 3;
  localparam int STAT_W = 4;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_SEND  = 2'd1,
    CMD_RECV  = 2'd2,
    CMD_STOP  = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RUN,
    ST_SEND,
    ST_RECV,
    ST_STOP
  } seq_st_e;
endpackage

// File: rtl/i2c_seq_buf.sv
module i2c_seq_buf #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [LW-1:0] lvl_q;
  logic          push_ok, pop_ok;

  assign empty_o = (lvl_q == '0);
  assign full_o  = (lvl_q == LW'(DEPTH));
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign rdata_o = mem[rd_q];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[g] <= '0;
      else if (push_ok && !clr_i && wr_q == AW'(g)) mem[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
    end else if (clr_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_ok) wr_q <= step(wr_q);
      if (pop_ok)  rd_q <= step(rd_q);
      lvl_q <= lvl_q + LW'(push_ok) - LW'(pop_ok);
    end
  end
endmodule

// File: rtl/i2c_seq_core.sv
module i2c_seq_core
  import i2c_seq_pkg::*;
#(
  parameter int CNT_W            = 16,
  parameter bit RESET_ON_DISABLE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic [6:0]        sa_i,
  input  logic [STAT_W-1:0] stat_clr_i,
  input  logic              done_i,
  input  logic              ack_i,
  input  logic              bus_busy_i,
  input  logic              buf_empty_i,
  input  logic              buf_full_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  cnt_cur_o,
  output logic              nack_o,
  output logic              ardy_o,
  output logic              xrdy_o,
  output logic              dir_rx_o,
  output logic              buf_clr_o,
  output logic              buf_pop_o,
  output logic              buf_push_o,
  output logic              cmd_valid_o,
  output bus_cmd_e          cmd_o,
  output logic [6:0]        cmd_addr_o
);
  seq_st_e           st_q, st_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  prog_q, prog_d, cur_q, cur_d;
  logic              nack_q, nack_d, ardy_q, ardy_d, xrdy_q, xrdy_d;
  logic              rx_q, rx_d;
  logic [6:0]        addr_q, addr_d;
  logic              start_req, kill, rpt, cnt_zero;

  assign rpt      = ctrl_q[B_RPT];
  assign cnt_zero = (cur_q == '0);
  assign kill     = RESET_ON_DISABLE && ctrl_we_i && !ctrl_wdata_i[B_EN];
  assign start_req = ctrl_we_i && ctrl_wdata_i[B_EN] && ctrl_wdata_i[B_MST]
                   && ctrl_wdata_i[B_STT] && !ctrl_wdata_i[B_XA] && !bus_busy_i;

  always_comb begin
    st_d       = st_q;
    ctrl_d     = ctrl_we_i ? (ctrl_wdata_i & CTRL_KEEP) : ctrl_q;
    prog_d     = cnt_we_i ? cnt_wdata_i : prog_q;
    cur_d      = cur_q;
    nack_d     = nack_q & ~stat_clr_i[S_NACK];
    ardy_d     = ardy_q & ~stat_clr_i[S_ARDY];
    xrdy_d     = xrdy_q;
    rx_d       = rx_q;
    addr_d     = addr_q;
    buf_clr_o  = 1'b0;
    buf_pop_o  = 1'b0;
    buf_push_o = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (start_req) begin
          st_d          = ST_ADDR;
          ctrl_d[B_STT] = 1'b0;
          rx_d          = ~ctrl_wdata_i[B_TRX];
          addr_d        = sa_i;
          xrdy_d        = 1'b0;
          buf_clr_o     = 1'b1;
        end
      end
      ST_ADDR: begin
        if (done_i) begin
          if (!ack_i) begin
            nack_d        = 1'b1;
            ctrl_d[B_STP] = 1'b0;
            st_d          = ST_IDLE;
          end else begin
            cur_d = prog_q;
            st_d  = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (rpt) begin
          if (ctrl_q[B_STP])              st_d = ST_STOP;
          else if (!rx_q && !buf_empty_i) st_d = ST_SEND;
          else if (rx_q && !buf_full_i)   st_d = ST_RECV;
        end else if (cnt_zero) begin
          if (ctrl_q[B_STP]) begin
            st_d = ST_STOP;
          end else begin
            ardy_d        = 1'b1;
            ctrl_d[B_MST] = 1'b0;
            xrdy_d        = 1'b0;
            st_d          = ST_IDLE;
          end
        end else if (!rx_q && !buf_empty_i) begin
          st_d = ST_SEND;
        end else if (rx_q && !buf_full_i) begin
          st_d = ST_RECV;
        end
      end
      ST_SEND: begin
        if (done_i) begin
          buf_pop_o = 1'b1;
          if (!rpt) cur_d = cur_q - CNT_W'(1);
          if (ack_i) begin
            xrdy_d = rpt || (cur_q != CNT_W'(1));
            st_d   = ST_RUN;
          end else begin
            nack_d        = 1'b1;
            ctrl_d[B_STP] = 1'b0;
            xrdy_d        = 1'b0;
            st_d          = ST_IDLE;
          end
        end
      end
      ST_RECV: begin
        if (done_i) begin
          buf_push_o = 1'b1;
          if (!rpt) cur_d = cur_q - CNT_W'(1);
          st_d = ST_RUN;
        end
      end
      ST_STOP: begin
        if (done_i) begin
          ctrl_d[B_STP] = 1'b0;
          cur_d         = prog_q;
          xrdy_d        = 1'b0;
          st_d          = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (kill) begin
      st_d       = ST_IDLE;
      ctrl_d     = '0;
      prog_d     = '0;
      cur_d      = '0;
      nack_d     = 1'b0;
      ardy_d     = 1'b0;
      xrdy_d     = 1'b0;
      rx_d       = 1'b0;
      buf_clr_o  = 1'b1;
      buf_pop_o  = 1'b0;
      buf_push_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ctrl_q <= '0;
      prog_q <= '0;
      cur_q  <= '0;
      nack_q <= 1'b0;
      ardy_q <= 1'b0;
      xrdy_q <= 1'b0;
      rx_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      ctrl_q <= ctrl_d;
      prog_q <= prog_d;
      cur_q  <= cur_d;
      nack_q <= nack_d;
      ardy_q <= ardy_d;
      xrdy_q <= xrdy_d;
      rx_q   <= rx_d;
      addr_q <= addr_d;
    end
  end

  always_comb begin
    cmd_valid_o = 1'b1;
    unique case (st_q)
      ST_ADDR: cmd_o = CMD_START;
      ST_SEND: cmd_o = CMD_SEND;
      ST_RECV: cmd_o = CMD_RECV;
      ST_STOP: cmd_o = CMD_STOP;
      default: begin
        cmd_o       = CMD_START;
        cmd_valid_o = 1'b0;
      end
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign cnt_cur_o  = cur_q;
  assign nack_o     = nack_q;
  assign ardy_o     = ardy_q;
  assign xrdy_o     = xrdy_q;
  assign dir_rx_o   = rx_q;
  assign cmd_addr_o = addr_q;
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_seq_pkg::*;
#(
  parameter int CNT_W            = 16,
  parameter int BUF_DEPTH        = 4,
  parameter bit RESET_ON_DISABLE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [15:0]       ctrl_wdata_i,
  output logic [15:0]       ctrl_o,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  output logic [CNT_W-1:0]  cnt_cur_o,
  input  logic [6:0]        sa_i,
  input  logic [3:0]        stat_clr_i,
  output logic [3:0]        stat_o,
  input  logic              tx_push_i,
  input  logic [7:0]        tx_byte_i,
  input  logic              rx_pop_i,
  output logic [7:0]        rx_byte_o,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_o,
  output logic [6:0]        cmd_addr_o,
  output logic              cmd_rd_o,
  output logic [7:0]        cmd_data_o,
  input  logic              done_i,
  input  logic              ack_i,
  input  logic [7:0]        rdata_i,
  input  logic              bus_busy_i
);
  logic     buf_clr, core_pop, core_push, buf_push, buf_pop;
  logic     buf_empty, buf_full, dir_rx;
  logic     nack, ardy, xrdy;
  logic [7:0] buf_head, buf_wdata;
  bus_cmd_e cmd;

  i2c_seq_core #(
    .CNT_W            (CNT_W),
    .RESET_ON_DISABLE (RESET_ON_DISABLE)
  ) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .cnt_we_i     (cnt_we_i),
    .cnt_wdata_i  (cnt_wdata_i),
    .sa_i         (sa_i),
    .stat_clr_i   (stat_clr_i),
    .done_i       (done_i),
    .ack_i        (ack_i),
    .bus_busy_i   (bus_busy_i),
    .buf_empty_i  (buf_empty),
    .buf_full_i   (buf_full),
    .ctrl_o       (ctrl_o),
    .cnt_cur_o    (cnt_cur_o),
    .nack_o       (nack),
    .ardy_o       (ardy),
    .xrdy_o       (xrdy),
    .dir_rx_o     (dir_rx),
    .buf_clr_o    (buf_clr),
    .buf_pop_o    (core_pop),
    .buf_push_o   (core_push),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_o        (cmd),
    .cmd_addr_o   (cmd_addr_o)
  );

  // software feeds the buffer in transmit, drains it in receive
  assign buf_push  = core_push | (tx_push_i & ~dir_rx);
  assign buf_pop   = core_pop | (rx_pop_i & dir_rx);
  assign buf_wdata = core_push ? rdata_i : tx_byte_i;

  i2c_seq_buf #(
    .DEPTH (BUF_DEPTH),
    .W     (8)
  ) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (buf_clr),
    .push_i  (buf_push),
    .wdata_i (buf_wdata),
    .pop_i   (buf_pop),
    .rdata_o (buf_head),
    .empty_o (buf_empty),
    .full_o  (buf_full)
  );

  assign cmd_o      = cmd;
  assign cmd_rd_o   = dir_rx;
  assign cmd_data_o = buf_head;
  assign rx_byte_o  = buf_head;

  always_comb begin
    stat_o         = '0;
    stat_o[S_NACK] = nack;
    stat_o[S_ARDY] = ardy;
    stat_o[S_RRDY] = dir_rx & ~buf_empty;
    stat_o[S_XRDY] = xrdy;
  end
endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk
  import i2c_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_we_i,
  input logic [15:0]      ctrl_o,
  input logic [CNT_W-1:0] cnt_cur_o,
  input logic [3:0]       stat_o,
  input logic             cmd_valid_o,
  input logic [1:0]       cmd_o,
  input logic             done_i,
  input logic             ack_i,
  input logic             bus_busy_i
);
  // R1
  ctrl_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o & ~CTRL_KEEP) == '0);

  // R2
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !done_i && !ctrl_we_i |=> cmd_valid_o && $stable(cmd_o));

  // R10
  start_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) && cmd_o == CMD_START |-> !$past(bus_busy_i));

  // R4
  send_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_o == CMD_SEND && !ctrl_o[B_RPT] |-> cnt_cur_o != '0);

  // R3
  addr_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_o == CMD_START && done_i && !ack_i && !ctrl_we_i
    |=> stat_o[S_NACK] && !ctrl_o[B_STP]);

  // R8
  data_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_o == CMD_SEND && done_i && !ack_i && !ctrl_we_i
    |=> stat_o[S_NACK] && !ctrl_o[B_STP] && !stat_o[S_XRDY]);

  // R6
  ardy_mst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[S_ARDY]) |-> !ctrl_o[B_MST]);
endmodule

bind i2c_xfer_seq i2c_seq_chk #(.CNT_W(CNT_W)) u_seq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .ctrl_o      (ctrl_o),
  .cnt_cur_o   (cnt_cur_o),
  .stat_o      (stat_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_o       (cmd_o),
  .done_i      (done_i),
  .ack_i       (ack_i),
  .bus_busy_i  (bus_busy_i)
);

// File: tb/test_i2c_xfer_seq.sv
module test_i2c_xfer_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int SETTLE = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [15:0] ctrl_o;
  logic cnt_we = 1'b0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic [CNT_W-1:0] cnt_cur;
  logic [6:0] sa = 7'h2A;
  logic [3:0] stat_clr = '0;
  logic [3:0] stat;
  logic tx_push = 1'b0;
  logic [7:0] tx_byte = '0;
  logic rx_pop = 1'b0;
  logic [7:0] rx_byte;
  logic cmd_valid;
  logic [1:0] cmd;
  logic [6:0] cmd_addr;
  logic cmd_rd;
  logic [7:0] cmd_data;
  logic done, ack;
  logic [7:0] rdata;
  logic bus_busy;

  // bus engine model
  logic eng_act, eng_busy;
  logic [1:0] eng_cnt;
  logic drop_busy = 1'b0;
  logic force_busy = 1'b0;
  logic addr_ack = 1'b1;
  int   nack_idx = -1;
  int   n_start, n_send, n_recv, n_stop;
  logic [6:0] last_addr;
  logic last_rd;
  logic [7:0] sent [64];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  assign bus_busy = eng_busy | force_busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_xfer_seq #(.CNT_W(CNT_W)) i_i2c_xfer_seq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ctrl_we_i    (ctrl_we),
    .ctrl_wdata_i (ctrl_wdata),
    .ctrl_o       (ctrl_o),
    .cnt_we_i     (cnt_we),
    .cnt_wdata_i  (cnt_wdata),
    .cnt_cur_o    (cnt_cur),
    .sa_i         (sa),
    .stat_clr_i   (stat_clr),
    .stat_o       (stat),
    .tx_push_i    (tx_push),
    .tx_byte_i    (tx_byte),
    .rx_pop_i     (rx_pop),
    .rx_byte_o    (rx_byte),
    .cmd_valid_o  (cmd_valid),
    .cmd_o        (cmd),
    .cmd_addr_o   (cmd_addr),
    .cmd_rd_o     (cmd_rd),
    .cmd_data_o   (cmd_data),
    .done_i       (done),
    .ack_i        (ack),
    .rdata_i      (rdata),
    .bus_busy_i   (bus_busy)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_act <= 1'b0; eng_cnt <= '0; eng_busy <= 1'b0;
      done <= 1'b0; ack <= 1'b0; rdata <= '0;
      n_start <= 0; n_send <= 0; n_recv <= 0; n_stop <= 0;
      last_addr <= '0; last_rd <= 1'b0;
    end else begin
      done <= 1'b0;
      if (drop_busy) eng_busy <= 1'b0;
      if (eng_act) begin
        if (eng_cnt == 0) begin
          eng_act <= 1'b0;
          done    <= 1'b1;
          ack     <= 1'b1;
          case (cmd)
            2'd0: begin
              ack <= addr_ack;
              if (addr_ack) eng_busy <= 1'b1;
              n_start <= n_start + 1;
              last_addr <= cmd_addr;
              last_rd <= cmd_rd;
            end
            2'd1: begin
              sent[n_send % 64] <= cmd_data;
              ack <= (n_send != nack_idx);
              n_send <= n_send + 1;
            end
            2'd2: begin
              rdata <= 8'h50 + 8'(n_recv);
              n_recv <= n_recv + 1;
            end
            default: begin
              eng_busy <= 1'b0;
              n_stop <= n_stop + 1;
            end
          endcase
        end else begin
          eng_cnt <= eng_cnt - 2'd1;
        end
      end else if (cmd_valid && !done) begin
        eng_act <= 1'b1;
        eng_cnt <= 2'd1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_cnt(input int v);
    @(negedge clk); cnt_we = 1'b1; cnt_wdata = CNT_W'(v);
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); tx_push = 1'b1; tx_byte = b;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic clr_stat(input logic [3:0] m);
    @(negedge clk); stat_clr = m;
    @(negedge clk); stat_clr = '0;
  endtask

  task automatic free_bus();
    @(negedge clk); drop_busy = 1'b1;
    @(negedge clk); drop_busy = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "ctrl after reset", ctrl_o, 0);
    chk("R11", "stat after reset", stat, 0);
    chk("R11", "count after reset", cnt_cur, 0);
    chk("R2", "no command after reset", cmd_valid, 0);
  endtask

  task automatic t_mask_and_refused();
    int s0 = n_start;
    wr_ctrl(16'hFFFF);
    cyc(20);
    chk("R1", "ctrl keeps mask", ctrl_o, 16'hCF87);
    chk("R10", "10-bit start refused", n_start - s0, 0);
    wr_ctrl(16'h0000);
    force_busy = 1'b1;
    wr_ctrl(16'h8601);
    cyc(20);
    chk("R10", "start refused while busy", n_start - s0, 0);
    chk("R10", "start bit kept while busy", ctrl_o, 16'h8601);
    force_busy = 1'b0;
    wr_ctrl(16'h8201);
    cyc(20);
    chk("R10", "start refused without master", n_start - s0, 0);
    chk("R10", "ctrl without master", ctrl_o, 16'h8201);
    wr_ctrl(16'h0000);
  endtask

  task automatic t_count_tx();
    int s0 = n_send;
    wr_cnt(3);
    wr_ctrl(16'h8601);
    cyc(SETTLE);
    chk("R2", "start address", last_addr, 7'h2A);
    chk("R2", "start direction write", last_rd, 0);
    chk("R2", "start bit cleared", ctrl_o, 16'h8600);
    push(8'hA1); push(8'hA2);
    cyc(SETTLE);
    chk("R11", "count after two bytes", cnt_cur, 1);
    chk("R4", "xrdy with count left", stat[3], 1);
    chk("R4", "no ardy yet", stat[1], 0);
    push(8'hA3);
    cyc(SETTLE);
    chk("R4", "bytes sent", n_send - s0, 3);
    for (int i = 0; i < 3; i++)
      chk("R4", "byte order", sent[(s0 + i) % 64], 8'hA1 + i);
    chk("R6", "ardy at zero", stat[1], 1);
    chk("R6", "master cleared", ctrl_o, 16'h8200);
    chk("R4", "xrdy clear at zero", stat[3], 0);
    chk("R11", "count zero", cnt_cur, 0);
    clr_stat(4'b0010);
    chk("R11", "ardy cleared by write", stat[1], 0);
    free_bus();
  endtask

  task automatic t_count_rx_stop();
    int r0 = n_recv;
    int p0 = n_stop;
    wr_cnt(3);
    wr_ctrl(16'h8403);
    cyc(SETTLE);
    chk("R2", "start direction read", last_rd, 1);
    chk("R5", "bytes received", n_recv - r0, 3);
    chk("R6", "stop issued", n_stop - p0, 1);
    chk("R6", "stop bit cleared", ctrl_o, 16'h8400);
    chk("R6", "count reloaded", cnt_cur, 3);
    chk("R6", "no ardy on stop", stat[1], 0);
    chk("R5", "rrdy set", stat[2], 1);
    for (int i = 0; i < 3; i++) begin
      chk("R5", "rx byte", rx_byte, 8'h50 + r0 + i);
      pop();
    end
    chk("R5", "rrdy clear when drained", stat[2], 0);
  endtask

  task automatic t_rx_full();
    int r0 = n_recv;
    wr_cnt(6);
    wr_ctrl(16'h8401);
    cyc(SETTLE);
    chk("R5", "fill stops at depth", n_recv - r0, 4);
    chk("R5", "count with full buffer", cnt_cur, 2);
    chk("R5", "oldest byte", rx_byte, 8'h50 + r0);
    pop();
    cyc(SETTLE);
    chk("R5", "fill resumes after pop", n_recv - r0, 5);
    chk("R11", "count after resume", cnt_cur, 1);
    pop();
    cyc(SETTLE);
    chk("R6", "ardy after last rx", stat[1], 1);
    chk("R6", "master dropped", ctrl_o, 16'h8000);
    chk("R5", "rrdy still set", stat[2], 1);
    clr_stat(4'b0010);
    free_bus();
  endtask

  task automatic t_addr_nack();
    int s0 = n_send;
    addr_ack = 1'b0;
    wr_cnt(2);
    wr_ctrl(16'h8603);
    push(8'h11);
    cyc(SETTLE);
    chk("R3", "nack flag", stat[0], 1);
    chk("R3", "stop bit cleared", ctrl_o, 16'h8600);
    chk("R3", "no data moved", n_send - s0, 0);
    chk("R3", "count untouched", cnt_cur, 0);
    clr_stat(4'b0001);
    chk("R11", "nack cleared by write", stat[0], 0);
    addr_ack = 1'b1;
  endtask

  task automatic t_data_nack();
    int s0 = n_send;
    nack_idx = n_send + 1;
    wr_cnt(4);
    wr_ctrl(16'h8603);
    push(8'hC0); push(8'hC1); push(8'hC2); push(8'hC3);
    cyc(SETTLE);
    chk("R8", "sends until nack", n_send - s0, 2);
    chk("R8", "nack flag", stat[0], 1);
    chk("R8", "stop bit cleared", ctrl_o, 16'h8600);
    chk("R8", "count includes nacked byte", cnt_cur, 2);
    chk("R8", "xrdy cleared", stat[3], 0);
    nack_idx = -1;
    clr_stat(4'b0001);
    free_bus();
  endtask

  task automatic t_repeat();
    int s0 = n_send;
    int p0 = n_stop;
    wr_cnt(1);
    wr_ctrl(16'h8605);
    push(8'hD0); push(8'hD1); push(8'hD2);
    cyc(SETTLE);
    chk("R7", "sends past count", n_send - s0, 3);
    chk("R7", "count not decremented", cnt_cur, 1);
    chk("R7", "xrdy in repeat", stat[3], 1);
    chk("R7", "no ardy in repeat", stat[1], 0);
    chk("R7", "no stop yet", n_stop - p0, 0);
    wr_ctrl(16'h8606);
    cyc(SETTLE);
    chk("R7", "stop on request", n_stop - p0, 1);
    chk("R7", "stop bit cleared", ctrl_o, 16'h8604);
    chk("R7", "bus released", bus_busy, 0);
  endtask

  task automatic t_disable();
    wr_cnt(0);
    wr_ctrl(16'h8601);
    cyc(SETTLE);
    chk("R6", "zero count gives ardy", stat[1], 1);
    free_bus();
    wr_cnt(7);
    wr_ctrl(16'h0000);
    cyc(2);
    chk("R9", "ctrl zero", ctrl_o, 0);
    chk("R9", "status zero", stat, 0);
    chk("R9", "count zero", cnt_cur, 0);
    wr_ctrl(16'h8601);
    cyc(SETTLE);
    chk("R9", "programmed count was reset", cnt_cur, 0);
    chk("R9", "ardy from reset count", stat[1], 1);
    free_bus();
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_mask_and_refused();
    t_count_tx();
    t_count_rx_stop();
    t_rx_full();
    t_addr_nack();
    t_data_nack();
    t_repeat();
    t_disable();
    finished = 1'b1;
  end

  initial begin
    int n = 0;
    while (!finished && n < 100000) begin
      @(negedge clk);
      n++;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule